// File: doc/BRIEF.md
# Sleep-State Power Management Controller

This block sequences a network controller between one active state and two sleep levels under host control. The host programs a two-bit mode field in a control register. A light sleep keeps the PHY and the receive-side MAC clocks running so that wake frames and magic packets can still be seen. A deep sleep stops every MAC and host-bus clock, puts the PHY into its reduced-power mode and waits for energy on the line. Pattern matching and energy sensing sit outside the block. Each one reports to it as a one-cycle detect pulse. A carrier level input is also taken, so a line that is already live counts as a detection at once.

A detection while asleep records its source in a wake-status field. It also sets a sticky interrupt status bit, whatever the event-output enable holds. The event output rises only when the enable for that sleep level and the event-output enable are both set. The event output then stays high until software clears the interrupt status. A write of any value to a dedicated wake register always takes the block back to active. After that write the ready flag stays low for a programmable number of cycles, which models the clocks starting up again. While ready is low, every other host write is dropped. The host bus is a plain single-cycle register port with a combinational read path. No flow control is needed at the block's edge, because every access completes in the cycle it is presented.

Top module: `pm_sleep_ctrl`

## Requirements
- R1: The mode field is control register (address 0) bits [1:0], with 00 = active, 01 = light sleep and 10 = deep sleep. It always reads the current state. Writing 01 or 10 while active and ready enters that state at the write edge. Writing 00 or 11 leaves the state unchanged.
- R2: The ready flag, control bit [8] and port `ready_o`, clears at the same edge that enters either sleep state.
- R3: In light sleep, a pulse on `frame_det_i` or `magic_det_i` sets the wake-status field, control bits [7:6], to 10 at the next edge. Detect pulses that arrive while active have no effect.
- R4: In deep sleep, a pulse on `energy_det_i` or a high `carrier_i` sets the wake-status field to 01 at the next edge. If the carrier is high on entry, the first deep-sleep cycle already detects it.
- R5: A light-sleep detection raises `pm_event_o` only when the wake-frame enable (control bit [2]) and the event-output enable (control bit [4]) are both set.
- R6: A deep-sleep detection raises `pm_event_o` only when the energy enable (control bit [3]) and the event-output enable are both set.
- R7: Every valid detection sets the interrupt status bit, interrupt register (address 1) bit [0], whatever the state of the event-output enable.
- R8: A write to address 2 with any data, while either sleep state is active, returns the state to active (mode reads 00) at that edge. A detection in that same cycle is still recorded.
- R9: While ready is low, writes to addresses 0 and 1 are ignored. Address 3 is unused: it reads 0 and ignores writes.
- R10: Clock enables in active: PHY, MAC core, MAC auxiliary and bus are all 1, and `phy_lowpower_o` is 0. In light sleep: PHY, MAC core and bus are 1, and MAC auxiliary is 0. In deep sleep: all four enables are 0 and `phy_lowpower_o` is 1.
- R11: Ready sets exactly RDY_DLY edges after the wake write edge.
- R12: Both status fields are write-one-to-clear. A 1 written to a control bit in [7:6] clears that wake-status bit. A 1 written to interrupt bit [0] clears the interrupt status and drops `pm_event_o`. Zeros change nothing.
- R13: `irq_o` is the interrupt status ANDed with the interrupt enable, control bit [5].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | ADDR_W | Host write address |
| wr_data | input | DATA_W | Host write data |
| rd_addr | input | ADDR_W | Host read address |
| rd_data | output | DATA_W | Combinational read data |
| frame_det_i | input | 1 | Wake-frame match pulse |
| magic_det_i | input | 1 | Magic-packet match pulse |
| energy_det_i | input | 1 | Line-energy detect pulse |
| carrier_i | input | 1 | Carrier present level |
| pm_event_o | output | 1 | Power-management event output |
| irq_o | output | 1 | Host interrupt |
| ready_o | output | 1 | Host may write again |
| clk_en_phy_o | output | 1 | PHY clock enable |
| clk_en_mac_core_o | output | 1 | Receive-side MAC clock enable |
| clk_en_mac_aux_o | output | 1 | Remaining MAC clock enable |
| clk_en_bus_o | output | 1 | Host bus clock enable |
| phy_lowpower_o | output | 1 | PHY reduced-power request |

## Verification
Two events can fall on the same edge: the wake write that ends a sleep, and a detect pulse in that final sleeping cycle. The bench forces this directly, issuing a wake-register write and a magic-packet pulse in the same cycle. It then expects the state to be active together with a recorded wake status of 10 and a set interrupt bit. Random traffic also produces the same collision, along with host writes that land in the cycle just before ready rises. A cycle-level reference model in the bench judges every one of those cycles.

// File: rtl/pm_pkg.sv
package pm_pkg;

  typedef enum logic [1:0] {
    PM_ACTIVE = 2'b00,
    PM_LIGHT  = 2'b01,
    PM_DEEP   = 2'b10
  } pm_state_e;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_INT  = 2'd1;
  localparam logic [1:0] ADDR_WAKE = 2'd2;

  localparam int unsigned F_MODE = 0;
  localparam int unsigned F_WOL  = 2;
  localparam int unsigned F_ED   = 3;
  localparam int unsigned F_EVT  = 4;
  localparam int unsigned F_IRQ  = 5;
  localparam int unsigned F_WS   = 6;
  localparam int unsigned F_RDY  = 8;
  localparam int unsigned CTRL_BITS = F_RDY + 1;

  localparam logic [1:0] WS_ENERGY = 2'b01;
  localparam logic [1:0] WS_FRAME  = 2'b10;

  typedef struct packed {
    logic wol;
    logic ed;
    logic evt;
    logic irq;
  } pm_en_t;

endpackage

// File: rtl/pm_wake_detect.sv
module pm_wake_detect
  import pm_pkg::*;
(
  input  pm_state_e  state_i,
  input  pm_en_t     en_i,
  input  logic       frame_det_i,
  input  logic       magic_det_i,
  input  logic       energy_det_i,
  input  logic       carrier_i,
  output logic       det_valid_o,
  output logic [1:0] det_code_o,
  output logic       det_evt_o
);

  logic light_hit;
  logic deep_hit;

  assign light_hit = (state_i == PM_LIGHT) && (frame_det_i || magic_det_i);
  assign deep_hit  = (state_i == PM_DEEP) && (energy_det_i || carrier_i);

  always_comb begin
    det_valid_o = 1'b0;
    det_code_o  = 2'b00;
    det_evt_o   = 1'b0;
    if (light_hit) begin
      det_valid_o = 1'b1;
      det_code_o  = WS_FRAME;
      det_evt_o   = en_i.wol && en_i.evt;
    end else if (deep_hit) begin
      det_valid_o = 1'b1;
      det_code_o  = WS_ENERGY;
      det_evt_o   = en_i.ed && en_i.evt;
    end
  end

endmodule

// File: rtl/pm_state_ctrl.sv
module pm_state_ctrl
  import pm_pkg::*;
#(
  parameter int unsigned RDY_DLY = 8
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sleep_req_i,
  input  pm_state_e sleep_tgt_i,
  input  logic      wake_wr_i,
  output pm_state_e state_o,
  output logic      ready_o,
  output logic      clk_en_phy_o,
  output logic      clk_en_mac_core_o,
  output logic      clk_en_mac_aux_o,
  output logic      clk_en_bus_o,
  output logic      phy_lowpower_o
);

  pm_state_e state_q;
  logic      wake_go;
  logic      enter_go;

  assign wake_go  = wake_wr_i && (state_q != PM_ACTIVE);
  assign enter_go = sleep_req_i && (state_q == PM_ACTIVE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PM_ACTIVE;
    end else if (wake_go) begin
      state_q <= PM_ACTIVE;
    end else if (enter_go) begin
      state_q <= sleep_tgt_i;
    end
  end

  generate
    if (RDY_DLY == 0) begin : g_rdy_now
      logic rdy_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          rdy_q <= 1'b1;
        end else if (wake_go) begin
          rdy_q <= 1'b1;
        end else if (enter_go) begin
          rdy_q <= 1'b0;
        end
      end
      assign ready_o = rdy_q;
    end else begin : g_rdy_cnt
      localparam int unsigned CNT_W = $clog2(RDY_DLY + 1);
      localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(RDY_DLY);
      localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
      logic [CNT_W-1:0] cnt_q;
      logic             rdy_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt_q <= '0;
          rdy_q <= 1'b1;
        end else if (wake_go) begin
          cnt_q <= CNT_LOAD;
          rdy_q <= 1'b0;
        end else if (cnt_q != '0) begin
          cnt_q <= cnt_q - CNT_ONE;
          if (cnt_q == CNT_ONE) begin
            rdy_q <= 1'b1;
          end
        end else if (enter_go) begin
          rdy_q <= 1'b0;
        end
      end
      assign ready_o = rdy_q;
    end
  endgenerate

  always_comb begin
    clk_en_phy_o      = 1'b1;
    clk_en_mac_core_o = 1'b1;
    clk_en_mac_aux_o  = 1'b1;
    clk_en_bus_o      = 1'b1;
    phy_lowpower_o    = 1'b0;
    case (state_q)
      PM_LIGHT: begin
        clk_en_mac_aux_o = 1'b0;
      end
      PM_DEEP: begin
        clk_en_phy_o      = 1'b0;
        clk_en_mac_core_o = 1'b0;
        clk_en_mac_aux_o  = 1'b0;
        clk_en_bus_o      = 1'b0;
        phy_lowpower_o    = 1'b1;
      end
      default: begin
      end
    endcase
  end

  assign state_o = state_q;

endmodule

// File: rtl/pm_host_regs.sv
module pm_host_regs
  import pm_pkg::*;
#(
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  pm_state_e         state_i,
  input  logic              ready_i,
  input  logic              det_valid_i,
  input  logic [1:0]        det_code_i,
  input  logic              det_evt_i,
  output pm_en_t            en_o,
  output logic [1:0]        wake_sts_o,
  output logic              int_sts_o,
  output logic              evt_o,
  output logic              sleep_req_o,
  output pm_state_e         sleep_tgt_o,
  output logic              wake_wr_o
);

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(ADDR_CTRL);
  localparam logic [ADDR_W-1:0] A_INT  = ADDR_W'(ADDR_INT);
  localparam logic [ADDR_W-1:0] A_WAKE = ADDR_W'(ADDR_WAKE);

  pm_en_t     en_q;
  logic [1:0] ws_q;
  logic       int_q;
  logic       evt_q;
  logic       acc;
  logic       ctrl_wr;
  logic       int_clr;
  logic [1:0] mode_wr;
  logic       unused_wr_hi;

  assign acc     = wr_en && ready_i;
  assign ctrl_wr = acc && (wr_addr == A_CTRL);
  assign int_clr = acc && (wr_addr == A_INT) && wr_data[0];
  assign mode_wr = wr_data[F_MODE +: 2];
  assign unused_wr_hi = ^wr_data[DATA_W-1:F_RDY];

  assign sleep_req_o = ctrl_wr && (mode_wr == PM_LIGHT || mode_wr == PM_DEEP);
  assign sleep_tgt_o = pm_state_e'(mode_wr);
  assign wake_wr_o   = wr_en && (wr_addr == A_WAKE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (ctrl_wr) begin
      en_q.wol <= wr_data[F_WOL];
      en_q.ed  <= wr_data[F_ED];
      en_q.evt <= wr_data[F_EVT];
      en_q.irq <= wr_data[F_IRQ];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ws_q <= 2'b00;
    end else begin
      if (ctrl_wr) begin
        ws_q <= ws_q & ~wr_data[F_WS +: 2];
      end
      if (det_valid_i) begin
        ws_q <= det_code_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_q <= 1'b0;
      evt_q <= 1'b0;
    end else begin
      if (int_clr) begin
        int_q <= 1'b0;
        evt_q <= 1'b0;
      end
      if (det_valid_i) begin
        int_q <= 1'b1;
        if (det_evt_i) begin
          evt_q <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_CTRL: begin
        rd_data[F_MODE +: 2] = state_i;
        rd_data[F_WOL]       = en_q.wol;
        rd_data[F_ED]        = en_q.ed;
        rd_data[F_EVT]       = en_q.evt;
        rd_data[F_IRQ]       = en_q.irq;
        rd_data[F_WS +: 2]   = ws_q;
        rd_data[F_RDY]       = ready_i;
      end
      A_INT: begin
        rd_data[0] = int_q;
      end
      default: begin
      end
    endcase
  end

  assign en_o       = en_q;
  assign wake_sts_o = ws_q;
  assign int_sts_o  = int_q;
  assign evt_o      = evt_q;

endmodule

// File: rtl/pm_sleep_ctrl.sv
module pm_sleep_ctrl
  import pm_pkg::*;
#(
  parameter int unsigned ADDR_W  = 2,
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned RDY_DLY = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              frame_det_i,
  input  logic              magic_det_i,
  input  logic              energy_det_i,
  input  logic              carrier_i,
  output logic              pm_event_o,
  output logic              irq_o,
  output logic              ready_o,
  output logic              clk_en_phy_o,
  output logic              clk_en_mac_core_o,
  output logic              clk_en_mac_aux_o,
  output logic              clk_en_bus_o,
  output logic              phy_lowpower_o
);

  pm_state_e  cur_state;
  pm_en_t     en;
  logic [1:0] wake_sts;
  logic       int_sts;
  logic       det_valid;
  logic [1:0] det_code;
  logic       det_evt;
  logic       sleep_req;
  pm_state_e  sleep_tgt;
  logic       wake_wr;

  pm_wake_detect u_detect (
    .state_i      (cur_state),
    .en_i         (en),
    .frame_det_i  (frame_det_i),
    .magic_det_i  (magic_det_i),
    .energy_det_i (energy_det_i),
    .carrier_i    (carrier_i),
    .det_valid_o  (det_valid),
    .det_code_o   (det_code),
    .det_evt_o    (det_evt)
  );

  pm_host_regs #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .rd_addr     (rd_addr),
    .rd_data     (rd_data),
    .state_i     (cur_state),
    .ready_i     (ready_o),
    .det_valid_i (det_valid),
    .det_code_i  (det_code),
    .det_evt_i   (det_evt),
    .en_o        (en),
    .wake_sts_o  (wake_sts),
    .int_sts_o   (int_sts),
    .evt_o       (pm_event_o),
    .sleep_req_o (sleep_req),
    .sleep_tgt_o (sleep_tgt),
    .wake_wr_o   (wake_wr)
  );

  pm_state_ctrl #(
    .RDY_DLY (RDY_DLY)
  ) u_state (
    .clk               (clk),
    .rst_n             (rst_n),
    .sleep_req_i       (sleep_req),
    .sleep_tgt_i       (sleep_tgt),
    .wake_wr_i         (wake_wr),
    .state_o           (cur_state),
    .ready_o           (ready_o),
    .clk_en_phy_o      (clk_en_phy_o),
    .clk_en_mac_core_o (clk_en_mac_core_o),
    .clk_en_mac_aux_o  (clk_en_mac_aux_o),
    .clk_en_bus_o      (clk_en_bus_o),
    .phy_lowpower_o    (phy_lowpower_o)
  );

  assign irq_o = int_sts && en.irq;

endmodule

// File: rtl/pm_sleep_ctrl_chk.sv
module pm_sleep_ctrl_chk
  import pm_pkg::*;
#(
  parameter int unsigned ADDR_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [1:0]        wr_mode,
  input logic              frame_det_i,
  input logic              magic_det_i,
  input logic              energy_det_i,
  input logic              carrier_i,
  input logic              ready_o,
  input logic              pm_event_o,
  input logic              clk_en_bus_o,
  input logic              clk_en_mac_core_o,
  input logic              phy_lowpower_o,
  input logic [1:0]        cur_state,
  input logic [1:0]        wake_sts,
  input logic              int_sts
);

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(ADDR_CTRL);
  localparam logic [ADDR_W-1:0] A_WAKE = ADDR_W'(ADDR_WAKE);

  // R2
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_state == PM_ACTIVE && ready_o && wr_en && wr_addr == A_CTRL &&
     (wr_mode == PM_LIGHT || wr_mode == PM_DEEP))
    |=> (!ready_o && cur_state != PM_ACTIVE));

  // R9
  locked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready_o && wr_en && wr_addr == A_CTRL) |=> $stable(cur_state));

  // R11
  ready_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_o) |-> (cur_state == PM_ACTIVE));

  // R5
  event_has_int_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pm_event_o |-> int_sts);

  // R3
  light_detect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_state == PM_LIGHT && (frame_det_i || magic_det_i))
    |=> (int_sts && wake_sts == WS_FRAME));

  // R4
  deep_detect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_state == PM_DEEP && (energy_det_i || carrier_i))
    |=> (int_sts && wake_sts == WS_ENERGY));

  // R10
  deep_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_state == PM_DEEP) |-> (!clk_en_bus_o && !clk_en_mac_core_o && phy_lowpower_o));

  // R8
  wake_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_state != PM_ACTIVE && wr_en && wr_addr == A_WAKE)
    |=> (cur_state == PM_ACTIVE));

endmodule

bind pm_sleep_ctrl pm_sleep_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk               (clk),
  .rst_n             (rst_n),
  .wr_en             (wr_en),
  .wr_addr           (wr_addr),
  .wr_mode           (wr_data[1:0]),
  .frame_det_i       (frame_det_i),
  .magic_det_i       (magic_det_i),
  .energy_det_i      (energy_det_i),
  .carrier_i         (carrier_i),
  .ready_o           (ready_o),
  .pm_event_o        (pm_event_o),
  .clk_en_bus_o      (clk_en_bus_o),
  .clk_en_mac_core_o (clk_en_mac_core_o),
  .phy_lowpower_o    (phy_lowpower_o),
  .cur_state         (cur_state),
  .wake_sts          (wake_sts),
  .int_sts           (int_sts)
);

// File: tb/pm_sleep_ctrl_bench.sv
module pm_sleep_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int RDY = 5;
  localparam int RAND_CYCLES = 3000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'd0;
  logic [15:0] wr_data = 16'd0;
  logic [1:0]  rd_addr = 2'd0;
  logic [15:0] rd_data;
  logic        frame_det_i = 1'b0;
  logic        magic_det_i = 1'b0;
  logic        energy_det_i = 1'b0;
  logic        carrier_i = 1'b0;
  logic        pm_event_o, irq_o, ready_o;
  logic        clk_en_phy_o, clk_en_mac_core_o, clk_en_mac_aux_o, clk_en_bus_o;
  logic        phy_lowpower_o;

  int n_chk = 0;
  int n_fail = 0;

  logic [1:0] m_mode = 2'd0;
  logic       m_ready = 1'b1;
  int         m_cnt = 0;
  logic       m_wol = 0, m_ed = 0, m_evt = 0, m_irq = 0;
  logic [1:0] m_ws = 2'd0;
  logic       m_int = 0, m_ev = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pm_sleep_ctrl #(.ADDR_W(2), .DATA_W(16), .RDY_DLY(RDY)) u_pm_sleep_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .frame_det_i(frame_det_i),
    .magic_det_i(magic_det_i), .energy_det_i(energy_det_i), .carrier_i(carrier_i),
    .pm_event_o(pm_event_o), .irq_o(irq_o), .ready_o(ready_o),
    .clk_en_phy_o(clk_en_phy_o), .clk_en_mac_core_o(clk_en_mac_core_o),
    .clk_en_mac_aux_o(clk_en_mac_aux_o), .clk_en_bus_o(clk_en_bus_o),
    .phy_lowpower_o(phy_lowpower_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [4:0] clk_exp(input logic [1:0] mode);
    case (mode)
      2'd1:    return 5'b11010;
      2'd2:    return 5'b00001;
      default: return 5'b11110;
    endcase
  endfunction

  task automatic rd(input logic [1:0] a, output logic [15:0] v);
    rd_addr = a;
    #1;
    v = rd_data;
  endtask

  task automatic compare_all();
    logic [15:0] c, i;
    rd(2'd0, c);
    rd(2'd1, i);
    chk("R1 mode field", c[1:0], m_mode);
    chk("R1 enable fields", c[5:2], {m_irq, m_evt, m_ed, m_wol});
    chk("R3 wake status", c[7:6], m_ws);
    chk("R11 ready bit", {c[8], ready_o}, {m_ready, m_ready});
    chk("R7 int status", i, {15'd0, m_int});
    chk("R5 event output", pm_event_o, m_ev);
    chk("R13 irq", irq_o, m_int & m_irq);
    chk("R10 clock enables",
        {clk_en_phy_o, clk_en_mac_core_o, clk_en_mac_aux_o, clk_en_bus_o, phy_lowpower_o},
        clk_exp(m_mode));
  endtask

  // Drives one cycle at a falling edge, advances the reference model, compares after the next rising edge.
  task automatic step(input logic we, input logic [1:0] a, input logic [15:0] d,
                      input logic fr, input logic mg, input logic en, input logic cr);
    logic dl, dd;
    logic [1:0] n_mode, n_ws;
    logic n_ready, n_wol, n_ed, n_evt, n_irq, n_int, n_ev;
    int n_cnt;
    wr_en = we; wr_addr = a; wr_data = d;
    frame_det_i = fr; magic_det_i = mg; energy_det_i = en; carrier_i = cr;
    dl = (m_mode == 2'd1) && (fr || mg);
    dd = (m_mode == 2'd2) && (en || cr);
    n_mode = m_mode; n_ws = m_ws; n_ready = m_ready; n_cnt = m_cnt;
    n_wol = m_wol; n_ed = m_ed; n_evt = m_evt; n_irq = m_irq; n_int = m_int; n_ev = m_ev;
    if (we && m_ready && a == 2'd0) begin
      n_wol = d[2]; n_ed = d[3]; n_evt = d[4]; n_irq = d[5];
      n_ws = n_ws & ~d[7:6];
      if (m_mode == 2'd0 && (d[1:0] == 2'd1 || d[1:0] == 2'd2)) begin
        n_mode = d[1:0];
        n_ready = 1'b0;
      end
    end
    if (we && m_ready && a == 2'd1 && d[0]) begin
      n_int = 1'b0; n_ev = 1'b0;
    end
    if (dl) begin
      n_ws = 2'b10; n_int = 1'b1;
      if (m_wol && m_evt) n_ev = 1'b1;
    end
    if (dd) begin
      n_ws = 2'b01; n_int = 1'b1;
      if (m_ed && m_evt) n_ev = 1'b1;
    end
    if (we && a == 2'd2 && m_mode != 2'd0) begin
      n_mode = 2'd0; n_cnt = RDY; n_ready = 1'b0;
    end else if (m_cnt > 0) begin
      n_cnt = m_cnt - 1;
      if (n_cnt == 0) n_ready = 1'b1;
    end
    @(negedge clk);
    m_mode = n_mode; m_ws = n_ws; m_ready = n_ready; m_cnt = n_cnt;
    m_wol = n_wol; m_ed = n_ed; m_evt = n_evt; m_irq = n_irq; m_int = n_int; m_ev = n_ev;
    compare_all();
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step(1'b0, 2'd0, 16'd0, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog expired act=running exp=finished");
    summary();
    $finish;
  end

  initial begin
    logic [15:0] v;
    logic cr_hold;
    void'($urandom(32'd715));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // Reset state
    rd(2'd0, v);
    chk("R11 reset ctrl readback", v, 16'h0100);
    chk("R10 reset clocks",
        {clk_en_phy_o, clk_en_mac_core_o, clk_en_mac_aux_o, clk_en_bus_o, phy_lowpower_o}, 5'b11110);
    @(negedge clk);

    // Light sleep with wake-frame and event enables, irq enabled
    step(1'b1, 2'd0, 16'h0035, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R2 ready low after light entry", ready_o, 1'b0);
    chk("R10 light aux clock off", clk_en_mac_aux_o, 1'b0);
    idle(2);
    step(1'b0, 2'd0, 16'd0, 1'b1, 1'b0, 1'b0, 1'b0);
    chk("R5 event after frame", pm_event_o, 1'b1);
    chk("R13 irq after frame", irq_o, 1'b1);
    // Locked writes: try to clear interrupt and rewrite control
    step(1'b1, 2'd1, 16'h0001, 1'b0, 1'b0, 1'b0, 1'b0);
    step(1'b1, 2'd0, 16'h00C0, 1'b0, 1'b0, 1'b0, 1'b0);
    rd(2'd1, v);
    chk("R9 int kept during lock", v[0], 1'b1);
    rd(2'd0, v);
    chk("R9 ctrl kept during lock", v[7:0], 8'hB5);
    // Wake write
    step(1'b1, 2'd2, 16'h1234, 1'b0, 1'b0, 1'b0, 1'b0);
    rd(2'd0, v);
    chk("R8 mode active after wake", v[1:0], 2'd0);
    idle(RDY - 1);
    chk("R11 ready still low", ready_o, 1'b0);
    idle(1);
    chk("R11 ready set after delay", ready_o, 1'b1);
    // Clear both status fields
    step(1'b1, 2'd1, 16'h0001, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R12 event dropped", pm_event_o, 1'b0);
    step(1'b1, 2'd0, 16'h00B4, 1'b0, 1'b0, 1'b0, 1'b0);
    rd(2'd0, v);
    chk("R12 wake status cleared", v[7:6], 2'b00);

    // Deep sleep, energy enable on, event enable off, carrier already present
    step(1'b1, 2'd0, 16'h000A, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R10 deep low power", phy_lowpower_o, 1'b1);
    step(1'b0, 2'd0, 16'd0, 1'b0, 1'b0, 1'b0, 1'b1);
    rd(2'd0, v);
    chk("R4 immediate carrier detect", v[7:6], 2'b01);
    chk("R6 no event without event enable", pm_event_o, 1'b0);
    rd(2'd1, v);
    chk("R7 int set without event enable", v[0], 1'b1);
    step(1'b1, 2'd2, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0);
    idle(RDY);
    step(1'b1, 2'd1, 16'h0001, 1'b0, 1'b0, 1'b0, 1'b0);
    step(1'b1, 2'd0, 16'h00C0, 1'b0, 1'b0, 1'b0, 1'b0);

    // Deep sleep with both enables: energy pulse
    step(1'b1, 2'd0, 16'h001A, 1'b0, 1'b0, 1'b0, 1'b0);
    idle(1);
    step(1'b0, 2'd0, 16'd0, 1'b1, 1'b0, 1'b1, 1'b0);
    chk("R6 event on energy", pm_event_o, 1'b1);
    step(1'b1, 2'd2, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0);
    idle(RDY);
    step(1'b1, 2'd1, 16'h0001, 1'b0, 1'b0, 1'b0, 1'b0);
    step(1'b1, 2'd0, 16'h00C0, 1'b0, 1'b0, 1'b0, 1'b0);

    // Collision: wake write and magic pulse in the same cycle, wake-frame enable off
    step(1'b1, 2'd0, 16'h0011, 1'b0, 1'b0, 1'b0, 1'b0);
    step(1'b1, 2'd2, 16'hFFFF, 1'b0, 1'b1, 1'b0, 1'b0);
    rd(2'd0, v);
    chk("R8 collision mode", v[1:0], 2'd0);
    chk("R3 collision wake status", v[7:6], 2'b10);
    chk("R5 collision no event", pm_event_o, 1'b0);
    idle(RDY);
    // Reserved and null mode writes
    step(1'b1, 2'd0, 16'h0003, 1'b0, 1'b0, 1'b0, 1'b0);
    rd(2'd0, v);
    chk("R1 mode 11 ignored", v[1:0], 2'd0);
    step(1'b1, 2'd3, 16'hFFFF, 1'b0, 1'b0, 1'b0, 1'b0);
    rd(2'd3, v);
    chk("R9 unused address reads zero", v, 16'd0);
    // Pulses while active ignored
    step(1'b1, 2'd0, 16'h00C0, 1'b0, 1'b0, 1'b0, 1'b0);
    step(1'b1, 2'd1, 16'h0001, 1'b0, 1'b0, 1'b0, 1'b0);
    step(1'b0, 2'd0, 16'd0, 1'b1, 1'b1, 1'b1, 1'b1);
    rd(2'd1, v);
    chk("R3 active pulses ignored", v[0], 1'b0);

    // Random traffic
    cr_hold = 1'b0;
    for (int n = 0; n < RAND_CYCLES; n++) begin
      logic we;
      logic [1:0] a;
      logic [15:0] d;
      we = ($urandom_range(0, 3) == 0);
      a = 2'($urandom_range(0, 3));
      d = 16'($urandom);
      if (a == 2'd0 && $urandom_range(0, 1) == 1) d[1:0] = 2'($urandom_range(1, 2));
      if ($urandom_range(0, 19) == 0) cr_hold = ~cr_hold;
      step(we, a, d, $urandom_range(0, 9) == 0, $urandom_range(0, 11) == 0,
           $urandom_range(0, 9) == 0, cr_hold);
    end
    idle(1);
    summary();
    $finish;
  end

endmodule